// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block is the combinational front end of instruction fetch for a small 32-bit processor that executes one instruction at a time. Each cycle it is given the current program counter and a window of six consecutive instruction-memory bytes, starting at that address. It breaks the leading byte into an opcode and a function code. From the opcode it decides whether a register-specifier byte follows and whether a four-byte constant word is present. It then extracts the two register fields and the constant, and computes the address of the next sequential instruction.

Instructions are 1, 2, 5 or 6 bytes long. The length comes only from the two presence decisions, so the rest of the window is ignored. Opcodes outside the defined set are flagged as invalid and are treated as single-byte instructions. The program counter register, the instruction memory, decode, execute and next-PC selection all sit outside this block.

Window byte k sits at bits [8k+7:8k] of `win_i`. Byte 0 is the byte at the PC.

Top module: `fetch_aligner`

## Requirements
- R1: `opcode_o` equals bits [7:4] of window byte 0, and `func_o` equals bits [3:0] of window byte 0.
- R2: `valid_o` is 1 for opcodes 0x0 to 0xB, which are: nop 0, halt 1, register move 2, immediate move 3, register-to-memory move 4, memory-to-register move 5, integer op 6, jump 7, call 8, return 9, push 0xA and pop 0xB. It is 0 for opcodes 0xC to 0xF.
- R3: `has_regs_o` is 1 exactly for opcodes 2, 3, 4, 5, 6, 0xA and 0xB.
- R4: `has_const_o` is 1 exactly for opcodes 3, 4, 5, 7 and 8.
- R5: When a register byte is present, `ra_o` is bits [7:4] of window byte 1 and `rb_o` is bits [3:0] of window byte 1.
- R6: When no register byte is present, `ra_o` and `rb_o` are both 8, meaning no register. The content of byte 1 has no effect on them.
- R7: When both a register byte and a constant are present, `valc_o` is window bytes 2 to 5 taken little-endian, with byte 2 as the least significant byte.
- R8: When a constant is present without a register byte, `valc_o` is window bytes 1 to 4 taken little-endian, and byte 5 has no effect. When no constant is present, `valc_o` is 0.
- R9: `valp_o` = PC + 1, plus 1 if a register byte is present, plus 4 if a constant is present. The sum is taken modulo 2^32.
- R10: For an invalid opcode, both presence flags are 0, `valp_o` is PC + 1, and the register fields read 8 whatever bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the instruction being fetched |
| win_i | input | 48 | Six memory bytes starting at pc_i; byte k at bits [8k+7:8k] |
| opcode_o | output | 4 | Opcode nibble of byte 0 |
| func_o | output | 4 | Function-code nibble of byte 0 |
| has_regs_o | output | 1 | Register-specifier byte present |
| has_const_o | output | 1 | Four-byte constant word present |
| ra_o | output | 4 | First register field, 8 if absent |
| rb_o | output | 4 | Second register field, 8 if absent |
| valc_o | output | 32 | Extracted constant, 0 if absent |
| valp_o | output | 32 | Fall-through address |
| valid_o | output | 1 | Opcode is a defined instruction |

## Verification
The hardest case to reach from the ports is the carry out of the fall-through adder. It only appears when the PC sits within a few bytes of the top of the address space and a long instruction is fetched. The bench sets the PC directly to 0xFFFFFFFC and 0xFFFFFFFF and fetches six- and five-byte instructions there to force the wrap.

Invalid opcodes are also hard to tell apart from valid ones. The bench pairs them with a register-shaped second byte, so it can show that the presence flags, register fields and length ignore that byte. It also fills the unused trailing window bytes with non-zero patterns, so that a misaligned constant shows up in `valc_o`.

// File: rtl/fa_pkg.sv
// Package fa_pkg: shared opcode encodings and constants for the fetch aligner.
// Assumes a 4-bit opcode nibble; values 0xC..0xF are undefined instructions.
package fa_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic [NIB_W-1:0] {
        OP_NOP   = 4'h0,
        OP_HALT  = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    // Register identifier meaning "no register access".
    localparam logic [NIB_W-1:0] REG_NONE = 4'h8;

endpackage

// File: rtl/fa_opcode_decode.sv
// Module fa_opcode_decode: splits the leading instruction byte into opcode and
// function code, and decodes the validity and the two presence predicates.
// Assumes the opcode is the high nibble. Undefined opcodes report no register
// byte and no constant, so they behave as one-byte instructions.
module fa_opcode_decode
    import fa_pkg::*;
(
    input  logic [7:0]       head_i,
    output logic [NIB_W-1:0] opcode_o,
    output logic [NIB_W-1:0] func_o,
    output logic             has_regs_o,
    output logic             has_const_o,
    output logic             valid_o
);

    assign opcode_o = head_i[7:4];
    assign func_o   = head_i[3:0];

    // Decode validity and the presence predicates from the opcode.
    always_comb begin
        has_regs_o  = 1'b0;
        has_const_o = 1'b0;
        valid_o     = 1'b1;
        case (opcode_o)
            OP_NOP, OP_HALT, OP_RET: ;
            OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: has_regs_o = 1'b1;
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                has_regs_o  = 1'b1;
                has_const_o = 1'b1;
            end
            OP_JUMP, OP_CALL: has_const_o = 1'b1;
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fa_field_extract.sv
// Module fa_field_extract: aligns the register fields and the constant word
// out of window bytes 1 onward. The constant starts one byte later when a
// register byte is present. Assumes little-endian constants; absent fields
// read as no-register and zero.
module fa_field_extract
    import fa_pkg::*;
#(
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [8*(WORD_BYTES+1)-1:0] tail_i,
    input  logic                        has_regs_i,
    input  logic                        has_const_i,
    output logic [NIB_W-1:0]            ra_o,
    output logic [NIB_W-1:0]            rb_o,
    output logic [8*WORD_BYTES-1:0]     valc_o
);

    localparam int unsigned WORD_W = 8 * WORD_BYTES;

    logic [WORD_W-1:0] word_after_regs;
    logic [WORD_W-1:0] word_direct;

    // Gather both candidate alignments of the constant, byte by byte.
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_word_byte
        assign word_direct[8*k +: 8]     = tail_i[8*k +: 8];
        assign word_after_regs[8*k +: 8] = tail_i[8*(k+1) +: 8];
    end

    // Select register fields, or force them to "none" when absent.
    always_comb begin
        if (has_regs_i) begin
            ra_o = tail_i[7:4];
            rb_o = tail_i[3:0];
        end else begin
            ra_o = REG_NONE;
            rb_o = REG_NONE;
        end
    end

    // Select the constant alignment, or zero when there is no constant.
    always_comb begin
        if (!has_const_i)
            valc_o = '0;
        else if (has_regs_i)
            valc_o = word_after_regs;
        else
            valc_o = word_direct;
    end

endmodule

// File: rtl/fa_next_pc.sv
// Module fa_next_pc: computes the fall-through address from the PC and the
// presence predicates. Assumes a one-byte head, an optional one-byte register
// specifier and an optional WORD_BYTES constant; wraps modulo 2^ADDR_W.
module fa_next_pc #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              has_regs_i,
    input  logic              has_const_i,
    output logic [ADDR_W-1:0] valp_o
);

    localparam logic [ADDR_W-1:0] HEAD_LEN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] REGS_LEN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] CONST_LEN = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] length;

    // Sum the instruction length from its parts.
    always_comb begin
        length = HEAD_LEN;
        if (has_regs_i)
            length = length + REGS_LEN;
        if (has_const_i)
            length = length + CONST_LEN;
    end

    assign valp_o = pc_i + length;

endmodule

// File: rtl/fetch_aligner.sv
// Module fetch_aligner: combinational variable-length instruction fetch front
// end. Takes the PC and a window of WORD_BYTES+2 bytes starting at the PC, and
// returns the opcode, function code, register fields, constant, fall-through
// address and validity. Assumes the caller holds the PC and the memory.
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0]           pc_i,
    input  logic [8*(WORD_BYTES+2)-1:0] win_i,
    output logic [3:0]                  opcode_o,
    output logic [3:0]                  func_o,
    output logic                        has_regs_o,
    output logic                        has_const_o,
    output logic [3:0]                  ra_o,
    output logic [3:0]                  rb_o,
    output logic [8*WORD_BYTES-1:0]     valc_o,
    output logic [ADDR_W-1:0]           valp_o,
    output logic                        valid_o
);

    localparam int unsigned WIN_W = 8 * (WORD_BYTES + 2);

    // Opcode split and predicates from byte 0.
    fa_opcode_decode u_decode (
        .head_i      (win_i[7:0]),
        .opcode_o    (opcode_o),
        .func_o      (func_o),
        .has_regs_o  (has_regs_o),
        .has_const_o (has_const_o),
        .valid_o     (valid_o)
    );

    // Field alignment from bytes 1 onward.
    fa_field_extract #(
        .WORD_BYTES (WORD_BYTES)
    ) u_extract (
        .tail_i      (win_i[WIN_W-1:8]),
        .has_regs_i  (has_regs_o),
        .has_const_i (has_const_o),
        .ra_o        (ra_o),
        .rb_o        (rb_o),
        .valc_o      (valc_o)
    );

    // Fall-through address.
    fa_next_pc #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_next_pc (
        .pc_i        (pc_i),
        .has_regs_i  (has_regs_o),
        .has_const_i (has_const_o),
        .valp_o      (valp_o)
    );

endmodule

// File: rtl/fa_checker.sv
// Module fa_checker: property checks on the fetch aligner ports. The block is
// combinational and has no clock, so the checks are immediate assertions
// re-evaluated whenever the ports change.
module fa_checker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input logic [ADDR_W-1:0]           pc_i,
    input logic [8*(WORD_BYTES+2)-1:0] win_i,
    input logic [3:0]                  opcode_o,
    input logic [3:0]                  func_o,
    input logic                        has_regs_o,
    input logic                        has_const_o,
    input logic [3:0]                  ra_o,
    input logic [3:0]                  rb_o,
    input logic [8*WORD_BYTES-1:0]     valc_o,
    input logic [ADDR_W-1:0]           valp_o,
    input logic                        valid_o
);

    localparam int unsigned WORD_W = 8 * WORD_BYTES;

    logic [ADDR_W-1:0] step;

    // Observed length of the instruction.
    always_comb step = valp_o - pc_i;

    // Check relations between the ports.
    always_comb begin
        p_split_r1: assert ({opcode_o, func_o} == win_i[7:0]);
        p_regs_none_r6: assert (has_regs_o || (ra_o == 4'h8 && rb_o == 4'h8));
        p_regs_field_r5: assert (!has_regs_o || {ra_o, rb_o} == win_i[15:8]);
        p_const_late_r7: assert (!(has_regs_o && has_const_o) || valc_o == win_i[16 +: WORD_W]);
        p_const_early_r8: assert (!(!has_regs_o && has_const_o) || valc_o == win_i[8 +: WORD_W]);
        p_const_zero_r8: assert (has_const_o || valc_o == '0);
        p_invalid_r10: assert (valid_o || (!has_regs_o && !has_const_o && step == ADDR_W'(1)));
        p_length_r9: assert (step == ADDR_W'(1) + ADDR_W'(has_regs_o)
                                     + (has_const_o ? ADDR_W'(WORD_BYTES) : ADDR_W'(0)));
    end

endmodule

bind fetch_aligner fa_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
) chk_i (
    .pc_i        (pc_i),
    .win_i       (win_i),
    .opcode_o    (opcode_o),
    .func_o      (func_o),
    .has_regs_o  (has_regs_o),
    .has_const_o (has_const_o),
    .ra_o        (ra_o),
    .rb_o        (rb_o),
    .valc_o      (valc_o),
    .valp_o      (valp_o),
    .valid_o     (valid_o)
);

// File: tb/fetch_aligner_tb_top.sv
`timescale 1ns/1ps
// Bench for fetch_aligner: a table of vectors walked by one loop, then
// directed tests for the reset state and address wrap-around.
module fetch_aligner_tb_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] pc;
    logic [47:0] win;
    logic [3:0]  opcode, func, ra, rb;
    logic        has_regs, has_const, valid;
    logic [31:0] valc, valp;
    int          checks;
    int          errors;
    bit          done;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    fetch_aligner dut_i (
        .pc_i        (pc),
        .win_i       (win),
        .opcode_o    (opcode),
        .func_o      (func),
        .has_regs_o  (has_regs),
        .has_const_o (has_const),
        .ra_o        (ra),
        .rb_o        (rb),
        .valc_o      (valc),
        .valp_o      (valp),
        .valid_o     (valid)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [47:0] win;
        logic        v;
        logic        r;
        logic        c;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] valc;
        logic [31:0] valp;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t TBL [NVEC] = '{
        '{32'h100,  48'h555555555500, 1'b1, 1'b0, 1'b0, 4'h8, 4'h8, 32'h0,        32'h101},
        '{32'h200,  48'hAAAAAAAAAA10, 1'b1, 1'b0, 1'b0, 4'h8, 4'h8, 32'h0,        32'h201},
        '{32'h300,  48'hFFFFFFFF3420, 1'b1, 1'b1, 1'b0, 4'h3, 4'h4, 32'h0,        32'h302},
        '{32'h400,  48'h12345678F230, 1'b1, 1'b1, 1'b1, 4'hF, 4'h2, 32'h12345678, 32'h406},
        '{32'h1000, 48'hDEADBEEF1540, 1'b1, 1'b1, 1'b1, 4'h1, 4'h5, 32'hDEADBEEF, 32'h1006},
        '{32'h20,   48'h999999996761, 1'b1, 1'b1, 1'b0, 4'h6, 4'h7, 32'h0,        32'h22},
        '{32'h500,  48'hEE4433221173, 1'b1, 1'b0, 1'b1, 4'h8, 4'h8, 32'h44332211, 32'h505},
        '{32'h600,  48'h770000004080, 1'b1, 1'b0, 1'b1, 4'h8, 4'h8, 32'h00000040, 32'h605},
        '{32'h700,  48'h123456789A90, 1'b1, 1'b0, 1'b0, 4'h8, 4'h8, 32'h0,        32'h701},
        '{32'h800,  48'h000000004FA0, 1'b1, 1'b1, 1'b0, 4'h4, 4'hF, 32'h0,        32'h802},
        '{32'h804,  48'h111111110FB0, 1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 32'h0,        32'h806},
        '{32'h900,  48'h000001002150, 1'b1, 1'b1, 1'b1, 4'h2, 4'h1, 32'h00000100, 32'h906},
        '{32'hA00,  48'h1234567834C0, 1'b0, 1'b0, 1'b0, 4'h8, 4'h8, 32'h0,        32'hA01},
        '{32'hB00,  48'hFFFFFFFFFFF5, 1'b0, 1'b0, 1'b0, 4'h8, 4'h8, 32'h0,        32'hB01}
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (pc=%0h win=%0h)", tag, act, exp, pc, win);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] w);
        @(negedge clk);
        pc  = p;
        win = w;
        #1;
    endtask

    task automatic check_vec(input vec_t t);
        check("R1 opcode", 48'(opcode), 48'(t.win[7:4]));
        check("R1 func",   48'(func),   48'(t.win[3:0]));
        check("R2/R10 valid", 48'(valid), 48'(t.v));
        check("R3 has_regs",  48'(has_regs), 48'(t.r));
        check("R4 has_const", 48'(has_const), 48'(t.c));
        check("R5/R6 ra", 48'(ra), 48'(t.ra));
        check("R5/R6 rb", 48'(rb), 48'(t.rb));
        check("R7/R8 valc", 48'(valc), 48'(t.valc));
        check("R9 valp", 48'(valp), 48'(t.valp));
    endtask

    // Watchdog: end a hung run as a failure.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        pc     = 32'h0;
        win    = 48'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all-zero inputs decode as a nop at address 0 (R2, R9, R6).
        apply(32'h0, 48'h0);
        check("R2 reset valid", 48'(valid), 48'h1);
        check("R9 reset valp",  48'(valp),  48'h1);
        check("R6 reset ra",    48'(ra),    48'h8);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i].pc, TBL[i].win);
            check_vec(TBL[i]);
        end

        // R9 wrap: six-byte instruction near the top of the address space.
        apply(32'hFFFF_FFFC, 48'h0000_0001_2330);
        check("R9 wrap six-byte valp", 48'(valp), 48'h2);
        check("R7 wrap valc", 48'(valc), 48'h1);

        // R9 wrap: five-byte call at the last address.
        apply(32'hFFFF_FFFF, 48'hFF00_0000_1080);
        check("R9 wrap call valp", 48'(valp), 48'h4);
        check("R8 call valc", 48'(valc), 48'h10);

        // R6: byte 1 changes but the register fields stay 8 for a jump.
        apply(32'h40, 48'h0000_0000_AB70);
        check("R6 jump ra", 48'(ra), 48'h8);
        check("R6 jump rb", 48'(rb), 48'h8);

        // R10: invalid opcode 0xD with a register-shaped byte 1.
        apply(32'h50, 48'h0102_0304_56D0);
        check("R10 invalid valp", 48'(valp), 48'h51);
        check("R10 invalid rb",   48'(rb),   48'h8);
        check("R10 invalid const", 48'(has_const), 48'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule